// File: doc/BRIEF.md
# Serial Configuration PROM Word Reader

This block reads 16-bit words from a three-wire serial PROM that holds 64 words. A host gives a 6-bit word address with a one-cycle request. The block then drives chip select, a serial clock and a command line to the PROM, and collects the 16 returned bits from the PROM's data line. When the word is complete, it presents the word with a one-cycle completion pulse.

The block also has a boot sequence. One pulse starts a sweep over every word of the PROM, from the lowest address to the highest. During the sweep the block keeps a 16-bit wrapping sum of all the words. It also unpacks a six-byte station address from the first three words. The serial clock comes from the system clock. A runtime half-period setting controls its speed, so one implementation can serve slow and fast parts.

Top module: `serial_prom_reader`

## Requirements
- R1: Each access begins with an 11-bit command sent MSB first: two zeros, a start one, the read code `10`, then the six address bits from a5 down to a0 (the bit pattern 0,0,1,1,0,a5..a0).
- R2: `ee_cs` goes high in the cycle the access starts, before the first rising edge of `ee_clk`, and stays high until the access ends.
- R3: `ee_mosi` changes only while `ee_clk` is low. While `ee_cs` is high, every level of `ee_clk` and `ee_cs` is held for at least `half_period` system cycles (`half_period` at least 1).
- R4: After the command, 16 data bits are clocked. `ee_miso` passes through a two-flop synchronizer and is sampled at the end of each high phase of the clock. The first bit received becomes bit 15 of `rd_data`. `half_period` must be at least 3.
- R5: When the block is not busy, `ee_cs`, `ee_clk` and `ee_mosi` are all 0.
- R6: For a host read, `busy` is high from the cycle after the accepted request until `done`. `done` is a one-cycle pulse in the cycle where `busy` falls. `rd_data` holds the word from `done` until the next word completes.
- R7: `req_valid` or `boot_start` raised while `busy` is high is ignored. It causes no access and no `done`.
- R8: The boot sequence reads addresses 0 to 63 in order and pulses `done` for each word. `busy` stays high across the whole sweep. `boot_done` pulses exactly once after the last word.
- R9: At `boot_done`, `checksum` holds the sum of all 64 words modulo 2^16.
- R10: At `boot_done`, byte i of `station_addr` (bits 8i+7..8i) holds the low byte of word i/2 when i is even, and the high byte when i is odd.
- R11: When `boot_start` and `req_valid` arrive in the same idle cycle, the boot sequence starts and the host request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| half_period | input | 8 | System cycles per serial clock level |
| req_valid | input | 1 | One-cycle host read request |
| req_addr | input | 6 | Word address for the host request |
| boot_start | input | 1 | Starts the full sweep |
| busy | output | 1 | Access or sweep in progress |
| done | output | 1 | One-cycle pulse when a word is complete |
| rd_data | output | 16 | Last word read |
| boot_done | output | 1 | One-cycle pulse at the end of the sweep |
| checksum | output | 16 | Wrapping sum of the swept words |
| station_addr | output | 48 | Six-byte station address from words 0 to 2 |
| ee_cs | output | 1 | PROM chip select |
| ee_clk | output | 1 | PROM serial clock |
| ee_mosi | output | 1 | Command bits to the PROM |
| ee_miso | input | 1 | Data bits from the PROM |

## Verification
The hardest case to reach is a request that arrives in the middle of an access. The bench must show that such a request leaves no trace on the wires or in the results. The stimulus starts a host read. While `busy` is high it raises both another read and a boot request, and it compares every later `done` against a queue that holds only the first word. The second tricky case is a same-cycle clash between boot and host requests. It is driven at the start of the sweep, where a wrong winner would show up at once as the wrong first address decoded by the PROM responder.

// File: rtl/spr_pkg.sv
package spr_pkg;
   typedef enum logic [2:0] {
      PH_IDLE,
      PH_CMD_LO,
      PH_CMD_HI,
      PH_DAT_LO,
      PH_DAT_HI,
      PH_CLOSE
   } spr_phase_t;
endpackage

// File: rtl/spr_sync.sv
module spr_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic d_out
);
   if (STAGES < 2) begin : g_bad_stages
      $error("spr_sync needs at least two stages");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[0] <= 1'b0;
      else        chain_q[0] <= d_in;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q[s] <= 1'b0;
         else        chain_q[s] <= chain_q[s-1];
      end
   end

   assign d_out = chain_q[STAGES-1];
endmodule

// File: rtl/spr_sk_timer.sv
module spr_sk_timer #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] half_period,
   output logic             tick
);
   if (DIV_W < 2) begin : g_bad_div
      $error("spr_sk_timer needs DIV_W of at least 2");
   end

   logic [DIV_W-1:0] cnt_q;
   logic [DIV_W-1:0] last;

   assign last = (half_period == '0) ? '0 : half_period - 1'b1;
   assign tick = run && (cnt_q == last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_q <= '0;
      else if (!run) cnt_q <= '0;
      else if (tick) cnt_q <= '0;
      else           cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/spr_word_engine.sv
module spr_word_engine
   import spr_pkg::*;
#(
   parameter int          ADDR_W   = 6,
   parameter int          DATA_W   = 16,
   parameter int          OPC_W    = 2,
   parameter logic [OPC_W-1:0] READ_OPC = 2'b10,
   parameter int          LEAD_W   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] addr,
   input  logic              tick,
   input  logic              din,
   output logic              eng_busy,
   output logic              done,
   output logic [DATA_W-1:0] data,
   output logic              cs,
   output logic              sk,
   output logic              dout
);
   localparam int CMD_W = LEAD_W + 1 + OPC_W + ADDR_W;
   localparam int MAX_W = (CMD_W > DATA_W) ? CMD_W : DATA_W;
   localparam int IDX_W = $clog2(MAX_W);

   if (DATA_W < 2) begin : g_bad_data
      $error("spr_word_engine needs DATA_W of at least 2");
   end

   spr_phase_t        ph_q;
   logic [CMD_W-1:0]  cmd_q;
   logic [IDX_W-1:0]  idx_q;
   logic [DATA_W-1:0] shift_q;
   logic [CMD_W-1:0]  cmd_word;

   assign cmd_word = {{LEAD_W{1'b0}}, 1'b1, READ_OPC, addr};
   assign eng_busy = (ph_q != PH_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q    <= PH_IDLE;
         cmd_q   <= '0;
         idx_q   <= '0;
         shift_q <= '0;
         data    <= '0;
         done    <= 1'b0;
         cs      <= 1'b0;
         sk      <= 1'b0;
         dout    <= 1'b0;
      end else begin
         done <= 1'b0;
         case (ph_q)
            PH_IDLE: if (start) begin
               cmd_q <= cmd_word;
               idx_q <= IDX_W'(CMD_W - 1);
               cs    <= 1'b1;
               sk    <= 1'b0;
               dout  <= cmd_word[CMD_W-1];
               ph_q  <= PH_CMD_LO;
            end
            PH_CMD_LO: if (tick) begin
               sk   <= 1'b1;
               ph_q <= PH_CMD_HI;
            end
            PH_CMD_HI: if (tick) begin
               sk <= 1'b0;
               if (idx_q == '0) begin
                  dout  <= 1'b0;
                  idx_q <= IDX_W'(DATA_W - 1);
                  ph_q  <= PH_DAT_LO;
               end else begin
                  idx_q <= idx_q - 1'b1;
                  dout  <= cmd_q[idx_q - 1'b1];
                  ph_q  <= PH_CMD_LO;
               end
            end
            PH_DAT_LO: if (tick) begin
               sk   <= 1'b1;
               ph_q <= PH_DAT_HI;
            end
            PH_DAT_HI: if (tick) begin
               shift_q <= {shift_q[DATA_W-2:0], din};
               sk      <= 1'b0;
               if (idx_q == '0) begin
                  ph_q <= PH_CLOSE;
               end else begin
                  idx_q <= idx_q - 1'b1;
                  ph_q  <= PH_DAT_LO;
               end
            end
            PH_CLOSE: if (tick) begin
               cs   <= 1'b0;
               dout <= 1'b0;
               data <= shift_q;
               done <= 1'b1;
               ph_q <= PH_IDLE;
            end
            default: ph_q <= PH_IDLE;
         endcase
      end
   end

   AST_CS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q != PH_IDLE) |-> cs); // R2
   AST_MOSI_SET_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sk) |-> $stable(dout)); // R3
   AST_SK_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sk) |-> $past(tick)); // R3
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R6
endmodule

// File: rtl/serial_prom_reader.sv
module serial_prom_reader #(
   parameter int ADDR_W    = 6,
   parameter int DATA_W    = 16,
   parameter int DIV_W     = 8,
   parameter int SYNC_W    = 2,
   parameter int MAC_BYTES = 6
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [DIV_W-1:0]       half_period,
   input  logic                   req_valid,
   input  logic [ADDR_W-1:0]      req_addr,
   input  logic                   boot_start,
   output logic                   busy,
   output logic                   done,
   output logic [DATA_W-1:0]      rd_data,
   output logic                   boot_done,
   output logic [DATA_W-1:0]      checksum,
   output logic [8*MAC_BYTES-1:0] station_addr,
   output logic                   ee_cs,
   output logic                   ee_clk,
   output logic                   ee_mosi,
   input  logic                   ee_miso
);
   localparam int N_WORDS     = 1 << ADDR_W;
   localparam int BYTES_PER_W = DATA_W / 8;
   localparam int MAC_WORDS   = (MAC_BYTES + BYTES_PER_W - 1) / BYTES_PER_W;

   if (DATA_W != 16) begin : g_bad_width
      $error("serial_prom_reader unpacks two bytes per word");
   end
   if (MAC_WORDS > N_WORDS) begin : g_bad_mac
      $error("station address does not fit in the PROM");
   end

   logic              eng_busy, eng_done, eng_start, tick, din_s;
   logic [ADDR_W-1:0] eng_addr;
   logic [DATA_W-1:0] eng_data;
   logic              host_go, boot_go;
   logic              boot_active_q, issue_q;
   logic [ADDR_W-1:0] ptr_q;
   logic [DATA_W-1:0] sum_q;
   logic [8*MAC_BYTES-1:0] mac_q, mac_nxt;
   logic              boot_done_q;

   assign busy      = eng_busy | boot_active_q;
   assign boot_go   = boot_start && !busy;
   assign host_go   = req_valid && !busy && !boot_start;
   assign eng_start = host_go | boot_go | (boot_active_q && issue_q);
   assign eng_addr  = boot_go ? '0 : (boot_active_q ? ptr_q : req_addr);

   spr_sync #(.STAGES(SYNC_W)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_in(ee_miso), .d_out(din_s)
   );

   spr_sk_timer #(.DIV_W(DIV_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .run(eng_busy),
      .half_period(half_period), .tick(tick)
   );

   spr_word_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_engine (
      .clk(clk), .rst_n(rst_n), .start(eng_start), .addr(eng_addr),
      .tick(tick), .din(din_s), .eng_busy(eng_busy), .done(eng_done),
      .data(eng_data), .cs(ee_cs), .sk(ee_clk), .dout(ee_mosi)
   );

   always_comb begin
      mac_nxt = mac_q;
      for (int b = 0; b < MAC_BYTES; b++) begin
         if (boot_active_q && eng_done && (ptr_q == ADDR_W'(b / BYTES_PER_W)))
            mac_nxt[8*b +: 8] = eng_data[8*(b % BYTES_PER_W) +: 8];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         boot_active_q <= 1'b0;
         issue_q       <= 1'b0;
         ptr_q         <= '0;
         sum_q         <= '0;
         mac_q         <= '0;
         boot_done_q   <= 1'b0;
      end else begin
         boot_done_q <= 1'b0;
         mac_q       <= mac_nxt;
         if (boot_go) begin
            boot_active_q <= 1'b1;
            issue_q       <= 1'b0;
            ptr_q         <= '0;
            sum_q         <= '0;
         end else if (boot_active_q) begin
            if (issue_q) issue_q <= 1'b0;
            if (eng_done) begin
               sum_q <= sum_q + eng_data;
               if (ptr_q == ADDR_W'(N_WORDS - 1)) begin
                  boot_active_q <= 1'b0;
                  boot_done_q   <= 1'b1;
               end else begin
                  ptr_q   <= ptr_q + 1'b1;
                  issue_q <= 1'b1;
               end
            end
         end
      end
   end

   assign done         = eng_done;
   assign rd_data      = eng_data;
   assign boot_done    = boot_done_q;
   assign checksum     = sum_q;
   assign station_addr = mac_q;

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!ee_cs && !ee_clk && !ee_mosi)); // R5
   AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |-> !eng_busy); // R7
   AST_BOOT_END_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      boot_done |-> !boot_active_q); // R8
endmodule

// File: tb/test_serial_prom_reader.sv
module test_serial_prom_reader;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  half_period = 8'd3;
   logic        req_valid = 1'b0;
   logic [5:0]  req_addr = '0;
   logic        boot_start = 1'b0;
   logic        busy, done, boot_done;
   logic [15:0] rd_data, checksum;
   logic [47:0] station_addr;
   logic        ee_cs, ee_clk, ee_mosi;
   logic        ee_miso = 1'b0;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   serial_prom_reader i_serial_prom_reader (
      .clk(clk), .rst_n(rst_n), .half_period(half_period),
      .req_valid(req_valid), .req_addr(req_addr), .boot_start(boot_start),
      .busy(busy), .done(done), .rd_data(rd_data), .boot_done(boot_done),
      .checksum(checksum), .station_addr(station_addr),
      .ee_cs(ee_cs), .ee_clk(ee_clk), .ee_mosi(ee_mosi), .ee_miso(ee_miso)
   );

   function automatic logic [15:0] rom(input int a);
      logic [15:0] v;
      v = 16'(a * 16'h9E37) ^ 16'h5A5A ^ 16'(a << 11);
      return v;
   endfunction

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // PROM responder
   int          edge_n = 0;
   logic [10:0] cmd_cap = '0;
   logic [5:0]  cur_addr = '0;
   always @(posedge ee_clk) begin
      logic [15:0] w;
      if (!ee_cs) begin
         check("R2 cs high at clock rise", 0, 1);
      end else begin
         edge_n = edge_n + 1;
         if (edge_n <= 11) cmd_cap = {cmd_cap[9:0], ee_mosi};
         if (edge_n == 11) begin
            cur_addr = cmd_cap[5:0];
            check("R1 command header", 64'(cmd_cap[10:6]), 64'h06);
         end
         if (edge_n >= 12 && edge_n <= 27) begin
            w = rom(int'(cur_addr));
            ee_miso <= w[27 - edge_n];
         end
      end
   end
   always @(negedge ee_cs) begin
      edge_n = 0;
      ee_miso <= 1'b0;
   end

   // scoreboard
   typedef struct { logic [5:0] a; logic [15:0] d; bit host; } item_t;
   item_t exp_q[$];
   int    boot_pulses = 0;

   always @(negedge clk) begin
      item_t it;
      if (rst_n && done) begin
         if (exp_q.size() == 0) begin
            check("R7 unexpected done", 1, 0);
         end else begin
            it = exp_q.pop_front();
            check("R4 read word", 64'(rd_data), 64'(it.d));
            check("R8 address order", 64'(cur_addr), 64'(it.a));
            if (it.host) check("R6 busy falls with done", 64'(busy), 0);
         end
      end
      if (rst_n && boot_done) boot_pulses++;
   end

   // wire timing monitor
   int   cyc = 0, last_chg = 0, hold_viol = 0, mosi_viol = 0;
   logic p_sk = 0, p_cs = 0, p_mosi = 0;
   always @(negedge clk) begin
      cyc++;
      if (ee_clk != p_sk || ee_cs != p_cs) begin
         if (p_cs && (cyc - last_chg) < int'(half_period)) hold_viol++;
         last_chg = cyc;
      end
      if (p_sk && ee_clk && ee_mosi != p_mosi) mosi_viol++;
      p_sk = ee_clk; p_cs = ee_cs; p_mosi = ee_mosi;
   end

   task automatic host_read(input logic [5:0] a);
      item_t it;
      it.a = a; it.d = rom(int'(a)); it.host = 1'b1;
      exp_q.push_back(it);
      @(negedge clk);
      req_addr  = a;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      check("R6 busy after request", 64'(busy), 1);
   endtask

   task automatic wait_idle();
      @(negedge clk);
      while (busy || exp_q.size() != 0) @(negedge clk);
      repeat (3) @(negedge clk);
      check("R5 lines idle", 64'({ee_cs, ee_clk, ee_mosi}), 0);
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      logic [15:0] sum;
      logic [47:0] mac;
      repeat (3) @(negedge clk);
      check("R5 reset lines", 64'({ee_cs, ee_clk, ee_mosi}), 0);
      check("R6 reset busy/done", 64'({busy, done, boot_done}), 0);
      check("R9 reset checksum", 64'(checksum), 0);
      rst_n = 1'b1;
      @(negedge clk);

      half_period = 8'd3;
      host_read(6'd0);  wait_idle();
      host_read(6'd63); wait_idle();
      host_read(6'd21); wait_idle();
      host_read(6'd42); wait_idle();
      check("R6 data held after done", 64'(rd_data), 64'(rom(42)));

      // R7: requests while busy must be ignored
      host_read(6'd5);
      repeat (10) @(negedge clk);
      req_addr = 6'd9; req_valid = 1'b1; boot_start = 1'b1;
      @(negedge clk);
      req_valid = 1'b0; boot_start = 1'b0;
      wait_idle();
      repeat (400) @(negedge clk);
      check("R7 no access after ignored request", 64'(busy), 0);
      check("R7 last address still 5", 64'(cur_addr), 5);

      half_period = 8'd5;
      host_read(6'd33); wait_idle();
      half_period = 8'd4;
      host_read(6'd12); wait_idle();

      // R11 + boot sweep R8 R9 R10
      half_period = 8'd3;
      sum = '0;
      for (int a = 0; a < 64; a++) begin
         item_t it;
         it.a = 6'(a); it.d = rom(a); it.host = 1'b0;
         exp_q.push_back(it);
         sum = sum + rom(a);
      end
      mac = {rom(2), rom(1), rom(0)};
      @(negedge clk);
      boot_start = 1'b1; req_valid = 1'b1; req_addr = 6'd50;
      @(negedge clk);
      boot_start = 1'b0; req_valid = 1'b0;
      while (!boot_done) @(negedge clk);
      check("R9 checksum", 64'(checksum), 64'(sum));
      check("R10 station address", 64'(station_addr), 64'(mac));
      check("R10 byte1 high of word0", 64'(station_addr[15:8]), 64'(rom(0) >> 8));
      wait_idle();
      check("R8 one boot_done pulse", 64'(boot_pulses), 1);
      check("R11 boot won, queue drained", 64'(exp_q.size()), 0);
      check("R3 level hold violations", 64'(hold_viol), 0);
      check("R3 mosi change while clock high", 64'(mosi_viol), 0);
      finish_run();
   end
endmodule